// File: doc/BRIEF.md
# Reference Detection Startup Sequencer

This controller runs the power-up sequence of a regulator whose soft-start pin can serve two purposes. A soft-start capacitor can sit on it, or an external DC reference can drive it. When enabled, the block first drains the pin for a fixed time. It then watches a synchronised comparator flag for a fixed window to decide whether an external source is holding the pin up.

The detection result picks the condition for soft-start completion:

- **Internal reference:** the internal ramp must finish and the output must also be near the reference.
- **External reference:** the internal ramp alone is enough.

A fixed delay follows before power good is raised. A select output tells the threshold monitors which reference to use:

- With an external reference detected, it points to the pin voltage from the end of detection.
- Without one, it points to the internal reference until power good rises, then switches to the pin.

All durations are given in microseconds and scaled by a cycles-per-microsecond parameter. One shared down-counter times every phase.

Top module: `refdet_seq`

## Requirements
- R1: `dischg_o` rises on the first clock edge that samples `en_i` high, and stays high for exactly DISCH_US*CYC_PER_US cycles.
- R2: `ext_ref_o` (1 = external reference present) is set at the end of the detect window only if the synchronised detect flag was high on every one of the DET_US*CYC_PER_US samples in the window. A single low sample gives 0. The result holds until enable falls.
- R3: The detect flag's value during the discharge phase has no effect on the detection result.
- R4: `ss_done_o` rises SS_US*CYC_PER_US cycles after the detection result is taken, and then stays high while enabled.
- R5: Without an external reference, soft-start completion also waits for the synchronised output-near flag to be high.
- R6: With an external reference, the output-near flag is ignored. The power-good timing is the same whatever its level.
- R7: `pgood_o` rises PG_US*CYC_PER_US cycles after soft-start completes.
- R8: Without an external reference, `thr_sel_o` (1 = pin voltage, 0 = internal reference) stays 0 until `pgood_o` rises, and goes to 1 in the same cycle.
- R9: With an external reference, `thr_sel_o` goes to 1 in the same cycle that `ext_ref_o` is set.
- R10: While `en_i` is low, all outputs are 0 in that same cycle. A new enable restarts the sequence from discharge.
- R11: Both comparator inputs pass through a two-flop synchroniser, which adds two cycles of latency before they take effect.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low aborts and clears the sequence |
| det_hi_i | input | 1 | Comparator: pin above detect threshold |
| fb_near_i | input | 1 | Comparator: output near internal reference |
| dischg_o | output | 1 | Pin discharge enable |
| ext_ref_o | output | 1 | Detection result, 1 = external reference |
| ss_done_o | output | 1 | Internal soft-start ramp finished |
| pgood_o | output | 1 | Power good |
| thr_sel_o | output | 1 | Threshold reference select, 1 = pin |

## Verification
All times are counted from the first clock edge that samples enable high. With D, W, S and P as the phase lengths in cycles:

- Discharge holds through edge D.
- The detection result appears after edge 1+D+W.
- Ramp done appears after edge 1+D+W+S.
- Power good appears after edge 1+D+W+S+P.

A late output-near flag adds 3+P edges from the cycle it is driven: two edges to synchronise, one to be seen, and P to count the delay. The bench drives and samples on falling edges. It checks each output one cycle before its due edge and again on that edge, so an off-by-one error shows. Dips in the detect flag are placed with the two-cycle synchroniser delay taken into account, both inside and just outside the window.

// File: rtl/refdet_pkg.sv
package refdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_DETECT,
    ST_SOFT,
    ST_FBWAIT,
    ST_PGDLY,
    ST_ON
  } seq_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refdet_sync.sv
module refdet_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/refdet_timer.sv
module refdet_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/refdet_fsm.sv
module refdet_fsm
  import refdet_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned DISCH_C = 125,
  parameter int unsigned DET_C   = 32,
  parameter int unsigned SS_C    = 2000,
  parameter int unsigned PG_C    = 1060
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          det_s_i,
  input  logic          fb_s_i,
  input  logic          tmr_zero_i,
  output logic          ld_o,
  output logic [CW-1:0] ld_val_o,
  output logic          dischg_o,
  output logic          ext_ref_o,
  output logic          ss_done_o,
  output logic          pgood_o,
  output logic          thr_sel_o
);
  // timer counts down to zero, so load length-1
  localparam logic [CW-1:0] DISCH_LD = CW'(DISCH_C - 1);
  localparam logic [CW-1:0] DET_LD   = CW'(DET_C - 1);
  localparam logic [CW-1:0] SS_LD    = CW'(SS_C - 1);
  localparam logic [CW-1:0] PG_LD    = CW'(PG_C - 1);

  seq_st_e st_q, st_d;
  logic    win_q, win_d;
  logic    ext_q, ext_d;
  logic    ss_q,  ss_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      win_q <= 1'b0;
      ext_q <= 1'b0;
      ss_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      ext_q <= ext_d;
      ss_q  <= ss_d;
    end
  end

  always_comb begin
    st_d     = st_q;
    win_d    = win_q;
    ext_d    = ext_q;
    ss_d     = ss_q;
    ld_o     = 1'b0;
    ld_val_o = '0;
    if (!en_i) begin
      st_d  = ST_IDLE;
      win_d = 1'b0;
      ext_d = 1'b0;
      ss_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d     = ST_DISCH;
          ld_o     = 1'b1;
          ld_val_o = DISCH_LD;
        end
        ST_DISCH: begin
          if (tmr_zero_i) begin
            st_d     = ST_DETECT;
            win_d    = 1'b1;
            ld_o     = 1'b1;
            ld_val_o = DET_LD;
          end
        end
        ST_DETECT: begin
          win_d = win_q & det_s_i;
          if (tmr_zero_i) begin
            ext_d    = win_q & det_s_i;
            st_d     = ST_SOFT;
            ld_o     = 1'b1;
            ld_val_o = SS_LD;
          end
        end
        ST_SOFT: begin
          if (tmr_zero_i) begin
            ss_d = 1'b1;
            if (ext_q || fb_s_i) begin
              st_d     = ST_PGDLY;
              ld_o     = 1'b1;
              ld_val_o = PG_LD;
            end else begin
              st_d = ST_FBWAIT;
            end
          end
        end
        ST_FBWAIT: begin
          if (fb_s_i) begin
            st_d     = ST_PGDLY;
            ld_o     = 1'b1;
            ld_val_o = PG_LD;
          end
        end
        ST_PGDLY: begin
          if (tmr_zero_i) st_d = ST_ON;
        end
        ST_ON: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // enable gates every output so a drop clears them in the same cycle
  assign dischg_o  = en_i && (st_q == ST_DISCH);
  assign ext_ref_o = en_i && ext_q;
  assign ss_done_o = en_i && ss_q;
  assign pgood_o   = en_i && (st_q == ST_ON);
  assign thr_sel_o = en_i && (ext_q || (st_q == ST_ON));
endmodule

// File: rtl/refdet_seq.sv
module refdet_seq
  import refdet_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned DISCH_US   = 125,
  parameter int unsigned DET_US     = 32,
  parameter int unsigned SS_US      = 2000,
  parameter int unsigned PG_US      = 1060
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic det_hi_i,
  input  logic fb_near_i,
  output logic dischg_o,
  output logic ext_ref_o,
  output logic ss_done_o,
  output logic pgood_o,
  output logic thr_sel_o
);
  localparam int unsigned DISCH_C = DISCH_US * CYC_PER_US;
  localparam int unsigned DET_C   = DET_US * CYC_PER_US;
  localparam int unsigned SS_C    = SS_US * CYC_PER_US;
  localparam int unsigned PG_C    = PG_US * CYC_PER_US;
  localparam int unsigned MAX_C   = max2(max2(DISCH_C, DET_C), max2(SS_C, PG_C));
  localparam int unsigned CW      = $clog2(MAX_C + 1);

  logic [1:0]    cmp_s;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tmr_zero;

  refdet_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fb_near_i, det_hi_i}),
    .q_o   (cmp_s)
  );

  refdet_timer #(.CW(CW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(tmr_zero)
  );

  refdet_fsm #(
    .CW     (CW),
    .DISCH_C(DISCH_C),
    .DET_C  (DET_C),
    .SS_C   (SS_C),
    .PG_C   (PG_C)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .det_s_i   (cmp_s[0]),
    .fb_s_i    (cmp_s[1]),
    .tmr_zero_i(tmr_zero),
    .ld_o      (ld),
    .ld_val_o  (ld_val),
    .dischg_o  (dischg_o),
    .ext_ref_o (ext_ref_o),
    .ss_done_o (ss_done_o),
    .pgood_o   (pgood_o),
    .thr_sel_o (thr_sel_o)
  );
endmodule

// File: rtl/refdet_seq_chk.sv
module refdet_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic dischg_o,
  input logic ext_ref_o,
  input logic ss_done_o,
  input logic pgood_o,
  input logic thr_sel_o
);
  a_r1_dischg_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dischg_o) |-> (!ext_ref_o && !ss_done_o && !pgood_o));

  a_r2_ext_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(ext_ref_o)) |-> ext_ref_o);

  a_r4_ss_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(ss_done_o)) |-> ss_done_o);

  a_r7_pg_after_ss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> ss_done_o);

  a_r8_sel_on_pg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> thr_sel_o);

  a_r9_sel_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_sel_o |-> (ext_ref_o || pgood_o));

  a_r10_off_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!dischg_o && !ext_ref_o && !ss_done_o && !pgood_o && !thr_sel_o));
endmodule

bind refdet_seq refdet_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .dischg_o (dischg_o),
  .ext_ref_o(ext_ref_o),
  .ss_done_o(ss_done_o),
  .pgood_o  (pgood_o),
  .thr_sel_o(thr_sel_o)
);

// File: tb/sim_refdet_seq.sv
module sim_refdet_seq;
  localparam int CLK_P = 10;
  localparam int D = 6, W = 4, S = 10, P = 5;
  localparam int T_DET = 1 + D + W;
  localparam int T_SS  = T_DET + S;
  localparam int T_PG  = T_SS + P;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, det = 1'b0, fb = 1'b0;
  logic dischg, ext_ref, ss_done, pgood, thr_sel;
  int   n_tests = 0, n_fail = 0;
  int   t = 0;

  always #(CLK_P/2) clk = ~clk;

  refdet_seq #(.CYC_PER_US(1), .DISCH_US(D), .DET_US(W), .SS_US(S), .PG_US(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .det_hi_i(det), .fb_near_i(fb),
    .dischg_o(dischg), .ext_ref_o(ext_ref), .ss_done_o(ss_done),
    .pgood_o(pgood), .thr_sel_o(thr_sel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at t=%0d: got %0b expected %0b", req, t, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to(input int n);
    if (n > t) begin
      repeat (n - t) @(posedge clk);
      @(negedge clk);
      t = n;
    end
  endtask

  task automatic prep(input logic d, input logic f);
    en = 1'b0; det = d; fb = f;
    wait_cyc(3);
    en = 1'b1; t = 0;
  endtask

  task automatic t_reset;
    en = 1'b1; det = 1'b1; fb = 1'b1;
    wait_cyc(3);
    chk("R12 dischg", dischg, 1'b0);
    chk("R12 ext_ref", ext_ref, 1'b0);
    chk("R12 pgood", pgood, 1'b0);
    chk("R12 thr_sel", thr_sel, 1'b0);
    en = 1'b0;
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_ext;
    prep(1'b1, 1'b0);
    #1 chk("R1 no dischg before edge", dischg, 1'b0);
    run_to(1);     chk("R1 dischg start", dischg, 1'b1);
    run_to(D);     chk("R1 dischg last", dischg, 1'b1);
    run_to(D + 1); chk("R1 dischg end", dischg, 1'b0);
    run_to(T_DET - 1); chk("R2 ext not yet", ext_ref, 1'b0);
                       chk("R9 sel not yet", thr_sel, 1'b0);
    run_to(T_DET); chk("R2 ext set", ext_ref, 1'b1);
                   chk("R9 sel at detect", thr_sel, 1'b1);
    run_to(T_SS - 1); chk("R4 ss not yet", ss_done, 1'b0);
    run_to(T_SS);     chk("R4 ss done", ss_done, 1'b1);
    run_to(T_PG - 1); chk("R6 pg not yet", pgood, 1'b0);
    run_to(T_PG);     chk("R6 pg with fb low", pgood, 1'b1);
    en = 1'b0;
    #1;
    chk("R10 pg clear", pgood, 1'b0);
    chk("R10 sel clear", thr_sel, 1'b0);
    chk("R10 ext clear", ext_ref, 1'b0);
    chk("R10 ss clear", ss_done, 1'b0);
  endtask

  task automatic t_int;
    prep(1'b0, 1'b1);
    run_to(T_DET);     chk("R2 no ext", ext_ref, 1'b0);
                       chk("R8 sel internal", thr_sel, 1'b0);
    run_to(T_SS);      chk("R4 ss done int", ss_done, 1'b1);
    run_to(T_PG - 1);  chk("R7 pg not yet", pgood, 1'b0);
                       chk("R8 sel before pg", thr_sel, 1'b0);
    run_to(T_PG);      chk("R7 pg", pgood, 1'b1);
                       chk("R8 sel at pg", thr_sel, 1'b1);
  endtask

  task automatic t_fbwait;
    prep(1'b0, 1'b0);
    run_to(T_SS);  chk("R5 ss done", ss_done, 1'b1);
    run_to(40);    chk("R5 pg waits fb", pgood, 1'b0);
                   chk("R5 sel waits", thr_sel, 1'b0);
    fb = 1'b1;
    run_to(40 + 2 + P); chk("R11 pg not yet", pgood, 1'b0);
    run_to(40 + 3 + P); chk("R11 pg after sync", pgood, 1'b1);
  endtask

  task automatic t_dip;
    prep(1'b1, 1'b1);
    run_to(8); det = 1'b0;
    run_to(9); det = 1'b1;
    run_to(T_DET); chk("R2 dip in window", ext_ref, 1'b0);
    run_to(T_PG);  chk("R2 result held", ext_ref, 1'b0);
                   chk("R8 sel after pg", thr_sel, 1'b1);
  endtask

  task automatic t_dip_late;
    prep(1'b1, 1'b1);
    run_to(T_DET); det = 1'b0;
    run_to(T_DET + 1); det = 1'b1;
    run_to(T_DET + 4); chk("R2 dip after window", ext_ref, 1'b1);
  endtask

  task automatic t_disch_ignore;
    prep(1'b0, 1'b0);
    run_to(3); det = 1'b1;
    run_to(T_DET); chk("R3 discharge low ignored", ext_ref, 1'b1);
  endtask

  task automatic t_restart;
    prep(1'b1, 1'b0);
    run_to(15); chk("R10 ext before drop", ext_ref, 1'b1);
    en = 1'b0;
    #1 chk("R10 ext drop", ext_ref, 1'b0);
    wait_cyc(2);
    en = 1'b1; t = 0;
    run_to(1);     chk("R10 restart dischg", dischg, 1'b1);
                   chk("R10 restart ss", ss_done, 1'b0);
    run_to(T_DET); chk("R10 restart ext", ext_ref, 1'b1);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ext();
    t_int();
    t_fbwait();
    t_dip();
    t_dip_late();
    t_disch_ignore();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule